// File: doc/BRIEF.md
# BCD Calendar Clock Register Page

This block keeps wall-clock time and a calendar date in a page of sixteen 4-bit registers. Every field is held as a pair of BCD digits, one for tens and one for units, at a fixed index. The exceptions are the weekday, which is a single digit, and three stored-only control nibbles. Each one-cycle pulse on `tick` adds one second. The carry then moves up the page one field per clock: seconds, minutes, hours, then day and weekday, then month, then year. The day limit depends on the month and on whether the two-digit year is a multiple of four.

A host controller can set or inspect any register. It uses an indexed nibble write port and a combinational nibble read port. It can load a starting time, read the running time, or place the clock just before a rollover. A write always wins over the clock's own update of the same register in the same cycle.

The carry walk is a small state machine. `ST_IDLE` waits for a tick and applies the seconds step. `ST_MIN`, `ST_HOUR`, `ST_DAY`, `ST_MON` and `ST_YEAR` each update their own field. The machine moves from one state to the next (IDLE→MIN→HOUR→DAY→MON→YEAR) only while the field just updated wrapped. Otherwise it returns to `ST_IDLE`. `ST_YEAR` always returns to `ST_IDLE`. A tick that arrives during the walk is held in one pending flag and is applied on the next `ST_IDLE` cycle.

Top module: `bcd_cal_page`

## Requirements
- R1: A synchronous active-high `rst` sets every register to 0, except day units (index 7) and month units (index 9), which become 1. This is 00:00:00, weekday 0, day 01, month 01, year 00.
- R2: Index map: 0/1 seconds units/tens, 2/3 minutes units/tens, 4/5 hours units/tens, 6 weekday, 7/8 day units/tens, 9/10 month units/tens, 11/12 year units/tens, 13 page, 14 test, 15 reset. A write with `wr_en` high stores `wr_data` at `wr_idx` on the clock edge. `rd_data` shows the register at `rd_idx` combinationally.
- R3: Seconds and minutes count 00 to 59 in BCD. Units 9 steps to 0 and increments the tens digit. 59 wraps to 00 and carries into the next field.
- R4: Hours count 00 to 23. 23 wraps to 00 and carries into the day.
- R5: The weekday counts 0 to 6. It steps on every day rollover, and 6 is followed by 0.
- R6: The last day of months 1 to 12 is 31, 28 (or 29, see R7), 31, 30, 31, 30, 31, 31, 30, 31, 30, 31. After the last day comes day 01 of the next month.
- R7: February has 29 days when the two-digit year is divisible by four. Year 00 counts as such a year.
- R8: After day 31 of month 12 the date becomes day 01, month 01, and the year increments. Year 99 wraps to 00.
- R9: When a host write and the clock's own update target the same register in the same cycle, the host value is stored.
- R10: Indices 13, 14 and 15 hold whatever is written to them and have no effect on counting.
- R11: The tick edge updates the seconds. Each further carry updates one field per following clock, so a full year carry ends five clocks after the tick edge. One tick arriving during the walk is held and applied once the walk returns to idle.
- R12: A time field whose binary value is at or above its top (59, 59, 23, the day limit, 12, 99) wraps to its floor on the next step and carries. This covers out-of-range values loaded by the host.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle pulse, advance by one second |
| wr_en | input | 1 | Host write strobe |
| wr_idx | input | 4 | Register index to write |
| wr_data | input | 4 | Nibble to write |
| rd_idx | input | 4 | Register index to read |
| rd_data | output | 4 | Nibble at `rd_idx` (combinational) |

## Verification
The bench builds the block with its default parameters: a seven-day week and a leap year every fourth year. It loads arbitrary starting points through the write port, so month ends, leap and non-leap Februaries, the year end and the 99-to-00 wrap are each reached with a single tick instead of years of counting. Directed cases then cover a write colliding with a tick, a tick queued behind a running carry walk, the stored-only nibbles, and an out-of-range seconds value.

// File: rtl/bcdcal_pkg.sv
package bcdcal_pkg;
    localparam int NIB_W = 4;
    localparam int NREGS = 16;
    localparam int IDX_W = $clog2(NREGS);
    localparam int BIN_W = 8;

    typedef logic [NIB_W-1:0] nib_t;

    localparam int IX_SEC_U  = 0;
    localparam int IX_SEC_T  = 1;
    localparam int IX_MIN_U  = 2;
    localparam int IX_MIN_T  = 3;
    localparam int IX_HR_U   = 4;
    localparam int IX_HR_T   = 5;
    localparam int IX_WDAY   = 6;
    localparam int IX_DAY_U  = 7;
    localparam int IX_DAY_T  = 8;
    localparam int IX_MON_U  = 9;
    localparam int IX_MON_T  = 10;
    localparam int IX_YR_U   = 11;
    localparam int IX_YR_T   = 12;

    localparam int SEC_TOP  = 59;
    localparam int MIN_TOP  = 59;
    localparam int HR_TOP   = 23;
    localparam int MON_TOP  = 12;
    localparam int YR_TOP   = 99;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_MIN,
        ST_HOUR,
        ST_DAY,
        ST_MON,
        ST_YEAR
    } walk_st_t;

    function automatic nib_t reset_value(input int idx);
        return (idx == IX_DAY_U || idx == IX_MON_U) ? nib_t'(1) : nib_t'(0);
    endfunction
endpackage

// File: rtl/bcd_step.sv
module bcd_step
    import bcdcal_pkg::*;
#(
    parameter int FLOOR = 0
) (
    input  logic [NIB_W-1:0] cur_t,
    input  logic [NIB_W-1:0] cur_u,
    input  logic [BIN_W-1:0] lim_b,
    output logic [NIB_W-1:0] nxt_t,
    output logic [NIB_W-1:0] nxt_u,
    output logic             wrap
);
    localparam logic [NIB_W-1:0] FL_T = NIB_W'(FLOOR / 10);
    localparam logic [NIB_W-1:0] FL_U = NIB_W'(FLOOR % 10);

    logic [BIN_W-1:0] cur_b;

    always_comb begin
        cur_b = BIN_W'(cur_t) * BIN_W'(10) + BIN_W'(cur_u);
        wrap  = (cur_b >= lim_b);
        if (wrap) begin
            nxt_t = FL_T;
            nxt_u = FL_U;
        end else if (cur_u >= NIB_W'(9)) begin
            nxt_t = cur_t + NIB_W'(1);
            nxt_u = '0;
        end else begin
            nxt_t = cur_t;
            nxt_u = cur_u + NIB_W'(1);
        end
    end
endmodule

// File: rtl/month_days.sv
module month_days
    import bcdcal_pkg::*;
#(
    parameter int LEAP_DIV = 4
) (
    input  logic [NIB_W-1:0] mon_t,
    input  logic [NIB_W-1:0] mon_u,
    input  logic [NIB_W-1:0] yr_t,
    input  logic [NIB_W-1:0] yr_u,
    output logic [BIN_W-1:0] last_day
);
    logic [BIN_W-1:0] mon_b;
    logic [BIN_W-1:0] yr_b;
    logic             leap;

    always_comb begin
        mon_b = BIN_W'(mon_t) * BIN_W'(10) + BIN_W'(mon_u);
        yr_b  = BIN_W'(yr_t) * BIN_W'(10) + BIN_W'(yr_u);
        leap  = ((yr_b % BIN_W'(LEAP_DIV)) == '0);
        unique case (mon_b)
            BIN_W'(2):  last_day = leap ? BIN_W'(29) : BIN_W'(28);
            BIN_W'(4),
            BIN_W'(6),
            BIN_W'(9),
            BIN_W'(11): last_day = BIN_W'(30);
            default:    last_day = BIN_W'(31);
        endcase
    end
endmodule

// File: rtl/bcd_cal_page.sv
module bcd_cal_page
    import bcdcal_pkg::*;
#(
    parameter int WEEK_LEN = 7,
    parameter int LEAP_DIV = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [NIB_W-1:0] wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [NIB_W-1:0] rd_data
);
    localparam nib_t WK_LAST = nib_t'(WEEK_LEN - 1);

    nib_t       regs    [NREGS];
    nib_t       upd_val [NREGS];
    logic [NREGS-1:0] upd_en;

    walk_st_t   st, st_nx;
    logic       pend, pend_nx;
    logic       go;

    nib_t sec_nt, sec_nu, min_nt, min_nu, hr_nt, hr_nu;
    nib_t day_nt, day_nu, mon_nt, mon_nu, yr_nt, yr_nu;
    nib_t wd_nx;
    logic sec_wrap, min_wrap, hr_wrap, day_wrap, mon_wrap, yr_wrap;
    logic [BIN_W-1:0] day_top;

    // field steppers
    bcd_step #(.FLOOR(0)) u_sec (
        .cur_t(regs[IX_SEC_T]), .cur_u(regs[IX_SEC_U]), .lim_b(BIN_W'(SEC_TOP)),
        .nxt_t(sec_nt), .nxt_u(sec_nu), .wrap(sec_wrap));
    bcd_step #(.FLOOR(0)) u_min (
        .cur_t(regs[IX_MIN_T]), .cur_u(regs[IX_MIN_U]), .lim_b(BIN_W'(MIN_TOP)),
        .nxt_t(min_nt), .nxt_u(min_nu), .wrap(min_wrap));
    bcd_step #(.FLOOR(0)) u_hr (
        .cur_t(regs[IX_HR_T]), .cur_u(regs[IX_HR_U]), .lim_b(BIN_W'(HR_TOP)),
        .nxt_t(hr_nt), .nxt_u(hr_nu), .wrap(hr_wrap));
    month_days #(.LEAP_DIV(LEAP_DIV)) u_mdays (
        .mon_t(regs[IX_MON_T]), .mon_u(regs[IX_MON_U]),
        .yr_t(regs[IX_YR_T]), .yr_u(regs[IX_YR_U]), .last_day(day_top));
    bcd_step #(.FLOOR(1)) u_day (
        .cur_t(regs[IX_DAY_T]), .cur_u(regs[IX_DAY_U]), .lim_b(day_top),
        .nxt_t(day_nt), .nxt_u(day_nu), .wrap(day_wrap));
    bcd_step #(.FLOOR(1)) u_mon (
        .cur_t(regs[IX_MON_T]), .cur_u(regs[IX_MON_U]), .lim_b(BIN_W'(MON_TOP)),
        .nxt_t(mon_nt), .nxt_u(mon_nu), .wrap(mon_wrap));
    bcd_step #(.FLOOR(0)) u_yr (
        .cur_t(regs[IX_YR_T]), .cur_u(regs[IX_YR_U]), .lim_b(BIN_W'(YR_TOP)),
        .nxt_t(yr_nt), .nxt_u(yr_nu), .wrap(yr_wrap));

    assign wd_nx = (regs[IX_WDAY] >= WK_LAST) ? '0 : regs[IX_WDAY] + nib_t'(1);
    assign go    = tick | pend;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= ST_IDLE;
            pend <= 1'b0;
        end else begin
            st   <= st_nx;
            pend <= pend_nx;
        end
    end

    // next state
    always_comb begin
        st_nx   = st;
        pend_nx = pend | tick;
        unique case (st)
            ST_IDLE: begin
                pend_nx = pend & tick;
                if (go && sec_wrap) st_nx = ST_MIN;
            end
            ST_MIN:  st_nx = min_wrap ? ST_HOUR : ST_IDLE;
            ST_HOUR: st_nx = hr_wrap  ? ST_DAY  : ST_IDLE;
            ST_DAY:  st_nx = day_wrap ? ST_MON  : ST_IDLE;
            ST_MON:  st_nx = mon_wrap ? ST_YEAR : ST_IDLE;
            ST_YEAR: st_nx = ST_IDLE;
            default: st_nx = ST_IDLE;
        endcase
    end

    // outputs of the walk: which nibbles it updates this cycle
    always_comb begin
        upd_en = '0;
        for (int i = 0; i < NREGS; i++) upd_val[i] = regs[i];
        unique case (st)
            ST_IDLE: begin
                if (go) begin
                    upd_en[IX_SEC_U] = 1'b1; upd_val[IX_SEC_U] = sec_nu;
                    upd_en[IX_SEC_T] = 1'b1; upd_val[IX_SEC_T] = sec_nt;
                end
            end
            ST_MIN: begin
                upd_en[IX_MIN_U] = 1'b1; upd_val[IX_MIN_U] = min_nu;
                upd_en[IX_MIN_T] = 1'b1; upd_val[IX_MIN_T] = min_nt;
            end
            ST_HOUR: begin
                upd_en[IX_HR_U] = 1'b1; upd_val[IX_HR_U] = hr_nu;
                upd_en[IX_HR_T] = 1'b1; upd_val[IX_HR_T] = hr_nt;
            end
            ST_DAY: begin
                upd_en[IX_DAY_U] = 1'b1; upd_val[IX_DAY_U] = day_nu;
                upd_en[IX_DAY_T] = 1'b1; upd_val[IX_DAY_T] = day_nt;
                upd_en[IX_WDAY]  = 1'b1; upd_val[IX_WDAY]  = wd_nx;
            end
            ST_MON: begin
                upd_en[IX_MON_U] = 1'b1; upd_val[IX_MON_U] = mon_nu;
                upd_en[IX_MON_T] = 1'b1; upd_val[IX_MON_T] = mon_nt;
            end
            ST_YEAR: begin
                upd_en[IX_YR_U] = 1'b1; upd_val[IX_YR_U] = yr_nu;
                upd_en[IX_YR_T] = 1'b1; upd_val[IX_YR_T] = yr_nt;
            end
            default: ;
        endcase
    end

    // register page: host write wins over walk update
    always_ff @(posedge clk) begin
        for (int i = 0; i < NREGS; i++) begin
            if (rst)
                regs[i] <= reset_value(i);
            else if (wr_en && wr_idx == IDX_W'(i))
                regs[i] <= wr_data;
            else if (upd_en[i])
                regs[i] <= upd_val[i];
        end
    end

    assign rd_data = regs[rd_idx];

    logic unused_ok;
    assign unused_ok = yr_wrap;
endmodule

module bcd_cal_page_chk
    import bcdcal_pkg::*;
#(
    parameter int WEEK_LEN = 7
) (
    input logic             clk,
    input logic             rst,
    input logic             tick,
    input logic             wr_en,
    input logic [IDX_W-1:0] wr_idx,
    input logic [NIB_W-1:0] wr_data,
    input walk_st_t         st,
    input logic             pend,
    input nib_t             regs [NREGS]
);
    logic [NREGS*NIB_W-1:0] flat;
    always_comb begin
        for (int i = 0; i < NREGS; i++) flat[i*NIB_W +: NIB_W] = regs[i];
    end

    // R2 R9
    host_write_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (regs[$past(wr_idx)] == $past(wr_data)));

    // R11
    walk_end_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_YEAR) |=> (st == ST_IDLE));

    // R11
    tick_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (st != ST_IDLE && tick) |=> pend);

    // R5
    weekday_step_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_DAY && !(wr_en && wr_idx == IDX_W'(IX_WDAY))) |=>
        (regs[IX_WDAY] == (($past(regs[IX_WDAY]) >= nib_t'(WEEK_LEN - 1)) ?
                           nib_t'(0) : $past(regs[IX_WDAY]) + nib_t'(1))));

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE && !tick && !pend && !wr_en) |=> $stable(flat));
endmodule

bind bcd_cal_page bcd_cal_page_chk #(.WEEK_LEN(WEEK_LEN)) u_chk (
    .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .st(st), .pend(pend), .regs(regs));

// File: tb/tb_bcd_cal_page.sv
module tb_bcd_cal_page;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 14;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [3:0] wr_idx = '0;
    logic [3:0] wr_data = '0;
    logic [3:0] rd_idx = '0;
    logic [3:0] rd_data;

    int checks = 0;
    int errors = 0;

    bcd_cal_page dut (
        .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(wr_data), .rd_idx(rd_idx), .rd_data(rd_data));

    always #(CLK_PERIOD/2) clk = ~clk;

    // packing: {yr, mon, day, 0/wday, hr, min, sec} as BCD bytes
    localparam logic [111:0] VEC [NV] = '{
        {56'h00_01_01_00_00_00_00, 56'h00_01_01_00_00_00_01}, // R3 plain second
        {56'h23_05_17_03_12_34_09, 56'h23_05_17_03_12_34_10}, // R3 units to tens
        {56'h23_05_17_03_12_34_59, 56'h23_05_17_03_12_35_00}, // R3 minute carry
        {56'h23_05_17_03_09_59_59, 56'h23_05_17_03_10_00_00}, // R4 hour carry
        {56'h23_05_17_03_23_59_59, 56'h23_05_18_04_00_00_00}, // R4 R5 day rollover
        {56'h23_05_18_06_23_59_59, 56'h23_05_19_00_00_00_00}, // R5 weekday 6 to 0
        {56'h23_04_30_02_23_59_59, 56'h23_05_01_03_00_00_00}, // R6 30-day month
        {56'h23_01_31_01_23_59_59, 56'h23_02_01_02_00_00_00}, // R6 31-day month
        {56'h23_02_28_01_23_59_59, 56'h23_03_01_02_00_00_00}, // R6 plain February
        {56'h24_02_28_01_23_59_59, 56'h24_02_29_02_00_00_00}, // R7 leap February
        {56'h24_02_29_02_23_59_59, 56'h24_03_01_03_00_00_00}, // R7 leap day end
        {56'h00_02_28_02_23_59_59, 56'h00_02_29_03_00_00_00}, // R7 year 00 leap
        {56'h23_12_31_05_23_59_59, 56'h24_01_01_06_00_00_00}, // R8 year end
        {56'h99_12_31_06_23_59_59, 56'h00_01_01_00_00_00_00}  // R8 century wrap
    };

    function automatic int bit_pos(input int i);
        return (i < 7) ? i * 4 : (i + 1) * 4;
    endfunction

    task automatic chk(input logic [55:0] act, input logic [55:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input int idx, input logic [3:0] val);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 4'(idx); wr_data = val;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic load_time(input logic [55:0] t);
        for (int i = 0; i < 13; i++) wr(i, t[bit_pos(i) +: 4]);
    endtask

    task automatic get_time(output logic [55:0] t);
        t = '0;
        for (int i = 0; i < 13; i++) begin
            rd_idx = 4'(i);
            #1;
            t[bit_pos(i) +: 4] = rd_data;
        end
    endtask

    task automatic rd_nib(input int idx, output logic [3:0] v);
        rd_idx = 4'(idx);
        #1;
        v = rd_data;
    endtask

    task automatic pulse_tick();
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0;
    endtask

    task automatic settle();
        repeat (8) @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [55:0] got;
        logic [3:0]  n;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state of every register
        for (int i = 0; i < 16; i++) begin
            rd_nib(i, n);
            chk(56'(n), (i == 7 || i == 9) ? 56'd1 : 56'd0, "R1");
        end

        // R2 R3 R4 R5 R6 R7 R8 table walk
        for (int i = 0; i < NV; i++) begin
            load_time(VEC[i][111:56]);
            pulse_tick();
            settle();
            get_time(got);
            chk(got, VEC[i][55:0], $sformatf("R2-table row %0d", i));
        end

        // R9 write collides with tick on seconds units
        load_time(56'h23_05_17_03_12_34_05);
        @(negedge clk);
        tick = 1'b1; wr_en = 1'b1; wr_idx = 4'd0; wr_data = 4'd7;
        @(negedge clk);
        tick = 1'b0; wr_en = 1'b0;
        settle();
        get_time(got);
        chk(got, 56'h23_05_17_03_12_34_07, "R9");

        // R10 stored-only nibbles
        wr(13, 4'hA);
        wr(14, 4'hF);
        wr(15, 4'h5);
        pulse_tick();
        settle();
        get_time(got);
        chk(got, 56'h23_05_17_03_12_34_08, "R10 time");
        rd_nib(13, n); chk(56'(n), 56'hA, "R10 idx13");
        rd_nib(14, n); chk(56'(n), 56'hF, "R10 idx14");
        rd_nib(15, n); chk(56'(n), 56'h5, "R10 idx15");

        // R11 second tick during a running carry walk is held
        load_time(56'h23_05_17_03_23_59_59);
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0;
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0;
        settle();
        get_time(got);
        chk(got, 56'h23_05_18_04_00_00_01, "R11");

        // R11 walk timing: year carry visible five clocks after tick edge
        load_time(56'h23_12_31_05_23_59_59);
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0;
        repeat (4) @(negedge clk);
        rd_nib(11, n); chk(56'(n), 56'h3, "R11 year not yet");
        @(negedge clk);
        rd_nib(11, n); chk(56'(n), 56'h4, "R11 year updated");

        // R12 out-of-range seconds wrap and carry
        load_time(56'h23_05_17_03_10_20_75);
        pulse_tick();
        settle();
        get_time(got);
        chk(got, 56'h23_05_17_03_10_21_00, "R12");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule